// File: doc/BRIEF.md
# ADC Hardware Start Trigger Qualifier

This block turns hardware trigger events into a one-cycle start request for an analog-to-digital converter sequencer. It picks one of three event sources: an external pin, a timer overflow pulse, or a PWM trigger. The chosen event is forwarded only when the trigger enable is set and the converter runs in single-cycle scan mode.

The external pin is asynchronous to the clock. It first passes through a two-flop synchronizer. A stability counter then measures how long the synchronized level has held. The pin can be qualified in four ways: as a low or high level held for a long window, or as a falling or rising edge whose new level then holds for a shorter window. A level trigger fires once per qualification and must leave its active level before it can fire again. The timer and PWM inputs are one-cycle pulses that pass straight to the start register.

The sequencer sets its start bit from `start_set`. The timer and PWM generators drive their pulses in the clock domain of this block.

Top module: `adc_trig_cond`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `start_set` is low, whatever the trigger inputs do.
- R2: With `pin_cond` = 2'b11 (rising edge), `trig_src` = 2'b00 (pin), `trig_en` = 1 and `conv_mode` = 2'b10 (single-cycle scan), a rise of `ext_pin` that lasts at least 4 clocks raises `start_set` for exactly one cycle. Counting the first clock edge that samples the new pin level as edge 1, `start_set` is high after edge 7.
- R3: With `pin_cond` = 2'b10 (falling edge), a fall of `ext_pin` that lasts at least 4 clocks raises `start_set` for one cycle, after edge 7 counted as in R2. Under this condition a rise gives no start.
- R4: An edge whose new level lasts only 3 clocks gives no start. A new level that lasts exactly 4 clocks gives one start, after edge 7.
- R5: With `pin_cond` = 2'b01 (high level), a pin held high gives exactly one start, after edge 11, no matter how long it stays high.
- R6: With `pin_cond` = 2'b00 (low level), a low lasting only 7 clocks gives no start. A low lasting 8 clocks or more gives one start, after edge 11.
- R7: After a level trigger has fired, the pin must leave the active level before a new start can occur. On its return, the 8-clock hold is counted again from the start.
- R8: With `trig_src` = 2'b01, a one-cycle `timer_ovf` pulse gives a one-cycle `start_set` in the following cycle.
- R9: With `trig_src` = 2'b11, a one-cycle `pwm_trig` pulse gives a one-cycle `start_set` in the following cycle.
- R10: With `trig_src` = 2'b10 (reserved), no input ever raises `start_set`.
- R11: With `trig_en` = 0, no input raises `start_set`.
- R12: With `conv_mode` at 2'b00, 2'b01 or 2'b11, no input raises `start_set`. Only 2'b10 lets triggers through.
- R13: Events on the sources that are not selected have no effect on `start_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_en | input | 1 | Hardware trigger enable |
| conv_mode | input | 2 | Converter operating mode; 2'b10 is single-cycle scan |
| trig_src | input | 2 | Source select: 00 pin, 01 timer, 10 reserved, 11 PWM |
| pin_cond | input | 2 | Pin condition: 00 low, 01 high, 10 falling, 11 rising |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| timer_ovf | input | 1 | Timer overflow pulse, one cycle wide |
| pwm_trig | input | 1 | PWM trigger pulse, one cycle wide |
| start_set | output | 1 | One-cycle request to set the converter start bit |

## Verification
The assertions check the following on every cycle:
- the gating rules: no start without the enable, outside single-cycle scan mode, or with the reserved source;
- the timer latency of one cycle;
- the qualifier's pulse: one cycle wide and only when the pin sits at the condition's target level.

Only the bench's scenarios can show the parts that depend on history:
- the exact 7-cycle and 11-cycle latencies;
- that 3-clock edges and 7-clock levels are rejected while 4-clock and 8-clock ones pass;
- re-arming of level triggers;
- that unselected sources have no effect.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  typedef enum logic [1:0] {
    SRC_PIN   = 2'b00,
    SRC_TIMER = 2'b01,
    SRC_RSVD  = 2'b10,
    SRC_PWM   = 2'b11
  } trig_src_e;

  typedef enum logic [1:0] {
    COND_LOW  = 2'b00,
    COND_HIGH = 2'b01,
    COND_FALL = 2'b10,
    COND_RISE = 2'b11
  } pin_cond_e;

  typedef enum logic [1:0] {
    MODE_SINGLE    = 2'b00,
    MODE_BURST     = 2'b01,
    MODE_SCAN_ONCE = 2'b10,
    MODE_SCAN_LOOP = 2'b11
  } conv_mode_e;

  // Upper bit of the condition selects edge qualification.
  function automatic logic cond_is_edge(pin_cond_e c);
    return c[1];
  endfunction

  // Lower bit is the level the pin must sit at (active level or post-edge level).
  function automatic logic cond_target(pin_cond_e c);
    return c[0];
  endfunction

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/adc_trig_pinqual.sv
module adc_trig_pinqual
  import adc_trig_pkg::*;
#(
  parameter int LEVEL_HOLD = 8,
  parameter int EDGE_HOLD  = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pin_s,
  input  pin_cond_e cond,
  output logic      hit
);

  localparam int MAX_HOLD = (LEVEL_HOLD > EDGE_HOLD) ? LEVEL_HOLD : EDGE_HOLD;
  localparam int CW       = $clog2(MAX_HOLD + 1);

  logic          pin_prev;
  logic [CW-1:0] run_len;
  logic          seen_change;

  logic          changed;
  logic          stepped;
  logic [CW-1:0] run_nxt;
  logic [CW-1:0] hold_tgt;
  logic          at_target;
  logic          qualify;

  always_comb begin
    changed   = (pin_s != pin_prev);
    stepped   = changed || (run_len != CW'(MAX_HOLD));
    if (changed)                      run_nxt = CW'(1);
    else if (run_len == CW'(MAX_HOLD)) run_nxt = run_len;
    else                              run_nxt = run_len + CW'(1);
    hold_tgt  = cond_is_edge(cond) ? CW'(EDGE_HOLD) : CW'(LEVEL_HOLD);
    at_target = (pin_s == cond_target(cond));
    // An edge run must have begun with a transition, not at reset.
    qualify   = stepped && (run_nxt == hold_tgt) && at_target &&
                (!cond_is_edge(cond) || seen_change || changed);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_prev    <= 1'b0;
      run_len     <= '0;
      seen_change <= 1'b0;
      hit         <= 1'b0;
    end else begin
      pin_prev    <= pin_s;
      run_len     <= run_nxt;
      seen_change <= seen_change | changed;
      hit         <= qualify;
    end
  end

  // R5 R7
  hit_single_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);

  // R2 R3 R6
  hit_level_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(pin_s) == cond_target($past(cond))));

endmodule

// File: rtl/adc_trig_gate.sv
module adc_trig_gate
  import adc_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  conv_mode_e mode,
  input  trig_src_e  src,
  input  logic       pin_hit,
  input  logic       tmr_pulse,
  input  logic       pwm_pulse,
  output logic       start_pulse
);

  logic picked;
  logic allowed;

  always_comb begin
    unique case (src)
      SRC_PIN:   picked = pin_hit;
      SRC_TIMER: picked = tmr_pulse;
      SRC_PWM:   picked = pwm_pulse;
      default:   picked = 1'b0;
    endcase
    allowed = en && (mode == MODE_SCAN_ONCE);
  end

  always_ff @(posedge clk) begin
    if (rst) start_pulse <= 1'b0;
    else     start_pulse <= allowed && picked;
  end

  // R11
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> $past(en));

  // R12
  mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> ($past(mode) == MODE_SCAN_ONCE));

  // R10
  rsvd_src_chk: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> ($past(src) != SRC_RSVD));

  // R8
  tmr_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (en && mode == MODE_SCAN_ONCE && src == SRC_TIMER && tmr_pulse) |=> start_pulse);

  // R9
  pwm_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (en && mode == MODE_SCAN_ONCE && src == SRC_PWM && pwm_pulse) |=> start_pulse);

endmodule

// File: rtl/adc_trig_cond.sv
module adc_trig_cond
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LEVEL_HOLD  = 8,
  parameter int EDGE_HOLD   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       trig_en,
  input  logic [1:0] conv_mode,
  input  logic [1:0] trig_src,
  input  logic [1:0] pin_cond,
  input  logic       ext_pin,
  input  logic       timer_ovf,
  input  logic       pwm_trig,
  output logic       start_set
);

  logic       pin_s;
  logic       pin_hit;
  trig_src_e  src_e;
  pin_cond_e  cond_e;
  conv_mode_e mode_e;

  assign src_e  = trig_src_e'(trig_src);
  assign cond_e = pin_cond_e'(pin_cond);
  assign mode_e = conv_mode_e'(conv_mode);

  adc_trig_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b0)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (ext_pin),
    .q_sync  (pin_s)
  );

  adc_trig_pinqual #(
    .LEVEL_HOLD (LEVEL_HOLD),
    .EDGE_HOLD  (EDGE_HOLD)
  ) u_qual (
    .clk   (clk),
    .rst   (rst),
    .pin_s (pin_s),
    .cond  (cond_e),
    .hit   (pin_hit)
  );

  adc_trig_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .en          (trig_en),
    .mode        (mode_e),
    .src         (src_e),
    .pin_hit     (pin_hit),
    .tmr_pulse   (timer_ovf),
    .pwm_pulse   (pwm_trig),
    .start_pulse (start_set)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !start_set);

endmodule

// File: tb/test_adc_trig_cond.sv
module test_adc_trig_cond;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst       = 1'b1;
  logic       trig_en   = 1'b1;
  logic [1:0] conv_mode = 2'b10;
  logic [1:0] trig_src  = 2'b01;
  logic [1:0] pin_cond  = 2'b11;
  logic       ext_pin   = 1'b0;
  logic       timer_ovf = 1'b0;
  logic       pwm_trig  = 1'b0;
  logic       start_set;

  int checks = 0;
  int errors = 0;

  adc_trig_cond i_adc_trig_cond (
    .clk       (clk),
    .rst       (rst),
    .trig_en   (trig_en),
    .conv_mode (conv_mode),
    .trig_src  (trig_src),
    .pin_cond  (pin_cond),
    .ext_pin   (ext_pin),
    .timer_ovf (timer_ovf),
    .pwm_trig  (pwm_trig),
    .start_set (start_set)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Samples start_set at the negedge after each of the next n posedges.
  task automatic watch(int n, output int first, output int cnt);
    first = -1;
    cnt   = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (start_set === 1'b1) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
  endtask

  // Changes configuration with the enable dropped first.
  task automatic setcfg(logic en, logic [1:0] mode, logic [1:0] src, logic [1:0] cond);
    @(negedge clk);
    trig_en = 1'b0;
    @(negedge clk);
    conv_mode = mode;
    trig_src  = src;
    pin_cond  = cond;
    @(negedge clk);
    trig_en = en;
  endtask

  task automatic settle(logic v);
    @(negedge clk);
    ext_pin = v;
    repeat (20) @(negedge clk);
  endtask

  task automatic drive_pin(logic v);
    @(negedge clk);
    ext_pin = v;
  endtask

  task automatic pulse_check(logic use_pwm, int exp_hi, string req);
    int s1, s2;
    @(negedge clk);
    if (use_pwm) pwm_trig = 1'b1; else timer_ovf = 1'b1;
    @(negedge clk);
    s1 = start_set;
    pwm_trig  = 1'b0;
    timer_ovf = 1'b0;
    @(negedge clk);
    s2 = start_set;
    chk(req, "start in cycle after pulse", s1, exp_hi);
    chk(req, "start one cycle later", s2, 0);
  endtask

  task automatic t_reset;
    timer_ovf = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1", "start during reset", start_set, 0);
    end
    rst = 1'b0;
    timer_ovf = 1'b0;
    @(negedge clk);
    chk("R1", "start after reset release", start_set, 0);
  endtask

  task automatic t_rise;
    int f, c;
    setcfg(1'b0, 2'b10, 2'b00, 2'b11);
    settle(1'b0);
    setcfg(1'b1, 2'b10, 2'b00, 2'b11);
    drive_pin(1'b1);
    watch(20, f, c);
    chk("R2", "rising edge latency", f, 7);
    chk("R2", "rising edge count", c, 1);
  endtask

  task automatic t_fall;
    int f, c;
    setcfg(1'b1, 2'b10, 2'b00, 2'b10);
    drive_pin(1'b1);
    watch(20, f, c);
    chk("R3", "rise under falling condition", c, 0);
    drive_pin(1'b0);
    watch(20, f, c);
    chk("R3", "falling edge latency", f, 7);
    chk("R3", "falling edge count", c, 1);
  endtask

  task automatic t_glitch;
    int f, c;
    setcfg(1'b1, 2'b10, 2'b00, 2'b11);
    drive_pin(1'b1);
    repeat (3) @(negedge clk);
    ext_pin = 1'b0;
    watch(25, f, c);
    chk("R4", "3-clock edge rejected", c, 0);
    drive_pin(1'b1);
    repeat (4) @(negedge clk);
    ext_pin = 1'b0;
    watch(25, f, c);
    chk("R4", "4-clock edge latency", f, 3);
    chk("R4", "4-clock edge count", c, 1);
  endtask

  task automatic t_level_high;
    int f, c;
    setcfg(1'b0, 2'b10, 2'b00, 2'b01);
    settle(1'b0);
    setcfg(1'b1, 2'b10, 2'b00, 2'b01);
    drive_pin(1'b1);
    watch(40, f, c);
    chk("R5", "high level latency", f, 11);
    chk("R5", "high level count while held", c, 1);
  endtask

  task automatic t_level_low;
    int f, c;
    setcfg(1'b1, 2'b10, 2'b00, 2'b00);
    drive_pin(1'b0);
    repeat (7) @(negedge clk);
    ext_pin = 1'b1;
    watch(30, f, c);
    chk("R6", "7-clock low rejected", c, 0);
    drive_pin(1'b0);
    watch(30, f, c);
    chk("R6", "low level latency", f, 11);
    chk("R6", "low level count", c, 1);
  endtask

  task automatic t_rearm;
    int f, c;
    drive_pin(1'b1);
    repeat (3) @(negedge clk);
    ext_pin = 1'b0;
    watch(30, f, c);
    chk("R7", "re-armed level latency", f, 11);
    chk("R7", "re-armed level count", c, 1);
  endtask

  task automatic t_timer;
    setcfg(1'b1, 2'b10, 2'b01, 2'b11);
    pulse_check(1'b0, 1, "R8");
  endtask

  task automatic t_pwm;
    setcfg(1'b1, 2'b10, 2'b11, 2'b11);
    pulse_check(1'b1, 1, "R9");
  endtask

  task automatic t_select;
    int f, c;
    setcfg(1'b1, 2'b10, 2'b11, 2'b11);
    pulse_check(1'b0, 0, "R13");
    setcfg(1'b1, 2'b10, 2'b01, 2'b11);
    pulse_check(1'b1, 0, "R13");
    drive_pin(1'b1);
    watch(20, f, c);
    chk("R13", "pin edge with timer selected", c, 0);
  endtask

  task automatic t_reserved;
    int f, c;
    setcfg(1'b1, 2'b10, 2'b10, 2'b10);
    pulse_check(1'b0, 0, "R10");
    pulse_check(1'b1, 0, "R10");
    drive_pin(1'b0);
    watch(20, f, c);
    chk("R10", "pin edge with reserved source", c, 0);
  endtask

  task automatic t_enable;
    int f, c;
    setcfg(1'b0, 2'b10, 2'b01, 2'b11);
    pulse_check(1'b0, 0, "R11");
    setcfg(1'b0, 2'b10, 2'b00, 2'b11);
    drive_pin(1'b1);
    watch(20, f, c);
    chk("R11", "pin edge with enable low", c, 0);
  endtask

  task automatic t_mode;
    setcfg(1'b1, 2'b00, 2'b01, 2'b11);
    pulse_check(1'b0, 0, "R12");
    setcfg(1'b1, 2'b01, 2'b01, 2'b11);
    pulse_check(1'b0, 0, "R12");
    setcfg(1'b1, 2'b11, 2'b01, 2'b11);
    pulse_check(1'b0, 0, "R12");
    setcfg(1'b1, 2'b10, 2'b01, 2'b11);
    pulse_check(1'b0, 1, "R12");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_rise();
    t_fall();
    t_glitch();
    t_level_high();
    t_level_low();
    t_rearm();
    t_timer();
    t_pwm();
    t_select();
    t_reserved();
    t_enable();
    t_mode();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule